// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Controller Router

This block turns level changes reported by PCI devices into levels on the inputs of a legacy 16-input interrupt controller. Each report gives the device/function number, the interrupt pin the device uses (0 to 3), and the new level. The block first maps the report onto one of four shared PCI interrupt lines. Three on-board slots have fixed lines. The four plug-in slots rotate the pin by their position. Any other slot uses its pin number as the line. The block stores the latest level of each line.

Each line has an 8-bit routing register. The register names the controller input that the line drives, or holds a value of 16 or more to leave the line unconnected. Each controller input is the OR of every line routed to it. The outputs are registered: an event or a routing write shows at the outputs one cycle after the edge that takes it in. The interrupt controller itself sits outside this block.

Top module: `irq_router`

## Requirements
- R1: After reset every routing register holds 0x80, every stored line level is 0, and all 16 `ctrl_irq` outputs are 0. After reset, a line routed to an input with no event stays low.
- R2: The slot number is `evt_devfn[7:3]`. The function bits `evt_devfn[2:0]` have no effect on the mapping.
- R3: Slot 10 always drives line 3, slot 11 drives line 1 and slot 12 drives line 2, whatever `evt_pin` is.
- R4: Slots 18 to 21 are plug-in slots. They drive line `((slot - 18) + evt_pin) mod 4`.
- R5: Any other slot drives the line equal to `evt_pin`.
- R6: When `evt_valid` is high at a clock edge, the level of the mapped line becomes `evt_level`. The other lines keep their levels. Without `evt_valid`, no line changes.
- R7: When `rt_wr` is high at a clock edge, routing register `rt_sel` (0 to 3, one per line) takes `rt_data`. A value from 0 to 15 connects the line to that controller input. A value of 16 to 255 connects the line to no input.
- R8: `ctrl_irq[c]` is the OR of the stored levels of every line whose routing register equals c.
- R9: `ctrl_irq` follows an event or a routing write one cycle after the edge that captured it, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Level-change report present this cycle |
| evt_devfn | input | 8 | Device/function number of the reporting device |
| evt_pin | input | 2 | Interrupt pin of the device, 0 to 3 |
| evt_level | input | 1 | New level of that pin |
| rt_wr | input | 1 | Routing register write strobe |
| rt_sel | input | 2 | Line whose routing register is written |
| rt_data | input | 8 | New routing value |
| ctrl_irq | output | 16 | Interrupt controller input levels |

## Verification
The bench sets the function bits of the device/function number to nonzero values. A design that mapped on the raw number would then pick the wrong line. The bench drives every fixed slot with pins that differ from their fixed lines, and plug-in slots whose rotation wraps past line 3. A design that dropped the modulo or checked the pin first would light the wrong input.

The bench also tests these cases:
- Two lines are merged onto one input and then cleared one at a time. A design that let the last writer win instead of OR-ing the lines would drop the input early.
- Routes are set to 15, 16 and 255. A design that truncated the route value would wrongly connect the line.
- The output is sampled in the cycle right after an event. A design without the output register would show the change one cycle too early.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int FN_BITS = 3;

   typedef struct packed {
      logic       hit;
      logic [1:0] line;
   } fixed_map_t;

   // on-board slots with wired interrupt lines
   function automatic fixed_map_t fixed_lookup(input int unsigned slot);
      fixed_map_t r;
      r = '{hit: 1'b0, line: 2'd0};
      case (slot)
         10: r = '{hit: 1'b1, line: 2'd3};
         11: r = '{hit: 1'b1, line: 2'd1};
         12: r = '{hit: 1'b1, line: 2'd2};
         default: r = '{hit: 1'b0, line: 2'd0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle
   import irq_router_pkg::*;
#(
   parameter int DEVFN_W    = 8,
   parameter int PIN_W      = 2,
   parameter int PLUG_FIRST = 18,
   parameter int PLUG_COUNT = 4
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [PIN_W-1:0]   pin,
   output logic [PIN_W-1:0]   line
);
   localparam int SLOT_W = DEVFN_W - FN_BITS;

   logic [SLOT_W-1:0] slot;
   fixed_map_t        fm;
   logic              in_plug;
   logic [PIN_W-1:0]  rot;

   assign slot    = devfn[DEVFN_W-1:FN_BITS];
   assign fm      = fixed_lookup(32'(slot));
   assign in_plug = (32'(slot) >= PLUG_FIRST) && (32'(slot) < PLUG_FIRST + PLUG_COUNT);
   assign rot     = PIN_W'(32'(slot) - PLUG_FIRST);

   always_comb begin
      if (fm.hit)
         line = PIN_W'(fm.line);
      else if (in_plug)
         line = pin + rot;
      else
         line = pin;
   end
endmodule

// File: rtl/irq_line_store.sv
module irq_line_store #(
   parameter int NUM_LINES = 4,
   parameter int LINE_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic [LINE_W-1:0]    evt_line,
   input  logic                 evt_level,
   output logic [NUM_LINES-1:0] line_lvl
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_lvl <= '0;
      end else begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (evt_valid && (evt_line == LINE_W'(i)))
               line_lvl[i] <= evt_level;
         end
      end
   end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
   parameter int NUM_LINES   = 4,
   parameter int SEL_W       = 2,
   parameter int NUM_CTRL    = 16,
   parameter int ROUTE_W     = 8,
   parameter int RESET_ROUTE = 128,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                rt_wr,
   input  logic [SEL_W-1:0]                    rt_sel,
   input  logic [ROUTE_W-1:0]                  rt_data,
   input  logic [NUM_LINES-1:0]                line_lvl,
   output logic [NUM_LINES-1:0][ROUTE_W-1:0]   route_q,
   output logic [NUM_CTRL-1:0]                 ctrl_irq
);
   logic [NUM_CTRL-1:0] merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LINES; l++)
            route_q[l] <= ROUTE_W'(RESET_ROUTE);
      end else if (rt_wr) begin
         route_q[rt_sel] <= rt_data;
      end
   end

   // a route value at or above NUM_CTRL matches no input
   always_comb begin
      merged = '0;
      for (int c = 0; c < NUM_CTRL; c++) begin
         for (int l = 0; l < NUM_LINES; l++) begin
            if (route_q[l] == ROUTE_W'(c))
               merged[c] = merged[c] | line_lvl[l];
         end
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) ctrl_irq <= '0;
            else        ctrl_irq <= merged;
         end
      end else begin : g_comb_out
         assign ctrl_irq = merged;
      end
   endgenerate
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int DEVFN_W     = 8,
   parameter int PIN_W       = 2,
   parameter int NUM_CTRL    = 16,
   parameter int ROUTE_W     = 8,
   parameter int PLUG_FIRST  = 18,
   parameter int PLUG_COUNT  = 4,
   parameter int RESET_ROUTE = 128,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [DEVFN_W-1:0]  evt_devfn,
   input  logic [PIN_W-1:0]    evt_pin,
   input  logic                evt_level,
   input  logic                rt_wr,
   input  logic [PIN_W-1:0]    rt_sel,
   input  logic [ROUTE_W-1:0]  rt_data,
   output logic [NUM_CTRL-1:0] ctrl_irq
);
   localparam int NUM_LINES = 1 << PIN_W;
   localparam int SLOT_W    = DEVFN_W - FN_BITS;

   generate
      if (DEVFN_W <= FN_BITS) begin : g_bad_devfn
         $error("DEVFN_W must leave room for a slot field");
      end
      if (PLUG_FIRST + PLUG_COUNT > (1 << SLOT_W)) begin : g_bad_plug
         $error("plug-in slots exceed the slot field");
      end
      if (NUM_CTRL > (1 << ROUTE_W)) begin : g_bad_ctrl
         $error("route field too narrow for NUM_CTRL");
      end
      if (RESET_ROUTE < NUM_CTRL || RESET_ROUTE >= (1 << ROUTE_W)) begin : g_bad_rst
         $error("reset route must be a disconnected value");
      end
   endgenerate

   logic [PIN_W-1:0]                       evt_line;
   logic [NUM_LINES-1:0]                   line_lvl;
   logic [NUM_LINES-1:0][ROUTE_W-1:0]      route_q;

   irq_swizzle #(
      .DEVFN_W(DEVFN_W), .PIN_W(PIN_W),
      .PLUG_FIRST(PLUG_FIRST), .PLUG_COUNT(PLUG_COUNT)
   ) u_swizzle (
      .devfn(evt_devfn), .pin(evt_pin), .line(evt_line)
   );

   irq_line_store #(
      .NUM_LINES(NUM_LINES), .LINE_W(PIN_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
      .evt_line(evt_line), .evt_level(evt_level), .line_lvl(line_lvl)
   );

   irq_route_matrix #(
      .NUM_LINES(NUM_LINES), .SEL_W(PIN_W), .NUM_CTRL(NUM_CTRL),
      .ROUTE_W(ROUTE_W), .RESET_ROUTE(RESET_ROUTE), .REG_OUT(REG_OUT)
   ) u_matrix (
      .clk(clk), .rst_n(rst_n), .rt_wr(rt_wr), .rt_sel(rt_sel),
      .rt_data(rt_data), .line_lvl(line_lvl), .route_q(route_q),
      .ctrl_irq(ctrl_irq)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int DEVFN_W    = 8,
   parameter int PIN_W      = 2,
   parameter int NUM_CTRL   = 16,
   parameter int ROUTE_W    = 8,
   parameter int PLUG_FIRST = 18,
   parameter int PLUG_COUNT = 4
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  evt_valid,
   input logic [DEVFN_W-1:0]                    evt_devfn,
   input logic [PIN_W-1:0]                      evt_pin,
   input logic                                  evt_level,
   input logic [(1<<PIN_W)-1:0]                 line_lvl,
   input logic [(1<<PIN_W)-1:0][ROUTE_W-1:0]    route_q,
   input logic [NUM_CTRL-1:0]                   ctrl_irq
);
   localparam int NUM_LINES = 1 << PIN_W;

   int unsigned      slot;
   logic             plug_hit;
   logic [PIN_W-1:0] plug_line;
   logic             all_off;

   assign slot      = 32'(evt_devfn >> 3);
   assign plug_hit  = evt_valid && slot >= PLUG_FIRST && slot < PLUG_FIRST + PLUG_COUNT;
   assign plug_line = PIN_W'(slot - PLUG_FIRST) + evt_pin;

   always_comb begin
      all_off = 1'b1;
      for (int l = 0; l < NUM_LINES; l++)
         if (32'(route_q[l]) < NUM_CTRL) all_off = 1'b0;
   end

   AST_SLOT10_LINE3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && slot == 10) |=> line_lvl[3] == $past(evt_level)); // R3

   AST_PLUG_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      plug_hit |=> line_lvl[$past(plug_line)] == $past(evt_level)); // R4

   AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(line_lvl)); // R6

   AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (all_off && $past(all_off)) |-> ctrl_irq == '0); // R7

   AST_ACTIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctrl_irq) <= NUM_LINES); // R8
endmodule

bind irq_router irq_router_chk #(
   .DEVFN_W(DEVFN_W), .PIN_W(PIN_W), .NUM_CTRL(NUM_CTRL),
   .ROUTE_W(ROUTE_W), .PLUG_FIRST(PLUG_FIRST), .PLUG_COUNT(PLUG_COUNT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_devfn(evt_devfn),
   .evt_pin(evt_pin), .evt_level(evt_level), .line_lvl(line_lvl),
   .route_q(route_q), .ctrl_irq(ctrl_irq)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [7:0]  evt_devfn = '0;
   logic [1:0]  evt_pin = '0;
   logic        evt_level = 1'b0;
   logic        rt_wr = 1'b0;
   logic [1:0]  rt_sel = '0;
   logic [7:0]  rt_data = '0;
   logic [15:0] ctrl_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic       lv [4];
   logic [7:0] rt [4];

   always #4 clk = ~clk;

   irq_router u_irq_router (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_devfn(evt_devfn),
      .evt_pin(evt_pin), .evt_level(evt_level), .rt_wr(rt_wr),
      .rt_sel(rt_sel), .rt_data(rt_data), .ctrl_irq(ctrl_irq)
   );

   function automatic int exp_line(input logic [7:0] devfn, input logic [1:0] pin);
      int s;
      s = int'(devfn[7:3]);
      if (s == 10) return 3;
      if (s == 11) return 1;
      if (s == 12) return 2;
      if (s >= 18 && s <= 21) return ((s - 18) + int'(pin)) % 4;
      return int'(pin);
   endfunction

   function automatic logic [15:0] exp_ctrl();
      logic [15:0] e;
      e = '0;
      for (int l = 0; l < 4; l++)
         if (lv[l] && rt[l] < 8'd16) e[rt[l][3:0]] = 1'b1;
      return e;
   endfunction

   task automatic check(input string req, input logic [15:0] exp);
      n_checks++;
      if (ctrl_irq !== exp) begin
         n_fail++;
         $display("FAIL %s ctrl_irq actual=%h expected=%h", req, ctrl_irq, exp);
      end
   endtask

   task automatic do_evt(input logic [7:0] devfn, input logic [1:0] pin, input logic lvl);
      @(negedge clk);
      evt_valid = 1'b1; evt_devfn = devfn; evt_pin = pin; evt_level = lvl;
      @(negedge clk);
      evt_valid = 1'b0;
      lv[exp_line(devfn, pin)] = lvl;
      @(negedge clk);
   endtask

   task automatic do_route(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      rt_wr = 1'b1; rt_sel = sel; rt_data = val;
      @(negedge clk);
      rt_wr = 1'b0;
      rt[sel] = val;
      @(negedge clk);
   endtask

   task automatic t_reset();
      for (int l = 0; l < 4; l++) begin lv[l] = 1'b0; rt[l] = 8'h80; end
      check("R1 reset outputs", 16'h0);
      do_route(2'd0, 8'd3);
      check("R1 line level reset low", 16'h0);
      do_route(2'd0, 8'h80);
      do_evt({5'd3, 3'd0}, 2'd1, 1'b1);
      check("R1 reset route disconnects", 16'h0);
      do_evt({5'd3, 3'd0}, 2'd1, 1'b0);
   endtask

   task automatic t_fixed();
      do_route(2'd0, 8'd5); do_route(2'd1, 8'd6);
      do_route(2'd2, 8'd7); do_route(2'd3, 8'd9);
      do_evt({5'd10, 3'd0}, 2'd0, 1'b1);
      check("R3 slot10 line3", exp_ctrl());
      do_evt({5'd11, 3'd0}, 2'd2, 1'b1);
      check("R3 slot11 line1", exp_ctrl());
      do_evt({5'd12, 3'd0}, 2'd3, 1'b1);
      check("R3 slot12 line2", exp_ctrl());
      do_evt({5'd10, 3'd0}, 2'd1, 1'b0);
      check("R6 clear line3 only", exp_ctrl());
      do_evt({5'd11, 3'd0}, 2'd0, 1'b0);
      do_evt({5'd12, 3'd0}, 2'd1, 1'b0);
      check("R6 all clear", 16'h0);
   endtask

   task automatic t_devfn();
      do_evt({5'd10, 3'd5}, 2'd0, 1'b1);
      check("R2 function bits ignored slot10", exp_ctrl());
      do_evt({5'd10, 3'd7}, 2'd2, 1'b0);
      check("R2 function bits ignored clear", 16'h0);
   endtask

   task automatic t_plug();
      do_evt({5'd20, 3'd0}, 2'd3, 1'b1);
      check("R4 slot20 pin3 wraps", exp_ctrl());
      do_evt({5'd21, 3'd1}, 2'd1, 1'b1);
      check("R4 slot21 pin1 wraps", exp_ctrl());
      do_evt({5'd18, 3'd0}, 2'd1, 1'b0);
      do_evt({5'd19, 3'd0}, 2'd1, 1'b1);
      check("R4 slot19 pin1", exp_ctrl());
      for (int l = 0; l < 4; l++) do_evt({5'd0, 3'd0}, 2'(l), 1'b0);
      check("R4 cleared", 16'h0);
   endtask

   task automatic t_pass();
      do_evt({5'd5, 3'd0}, 2'd2, 1'b1);
      check("R5 other slot pin2", exp_ctrl());
      do_evt({5'd22, 3'd0}, 2'd2, 1'b0);
      do_evt({5'd17, 3'd0}, 2'd3, 1'b1);
      check("R5 slot17 pin3 passthru", exp_ctrl());
      do_evt({5'd13, 3'd0}, 2'd3, 1'b0);
      check("R5 slot13 clears line3", 16'h0);
   endtask

   task automatic t_merge();
      do_route(2'd0, 8'd4); do_route(2'd1, 8'd4);
      do_evt({5'd1, 3'd0}, 2'd0, 1'b1);
      do_evt({5'd1, 3'd0}, 2'd1, 1'b1);
      check("R8 two lines merged", 16'h0010);
      do_evt({5'd1, 3'd0}, 2'd0, 1'b0);
      check("R8 one line still holds", 16'h0010);
      do_evt({5'd1, 3'd0}, 2'd1, 1'b0);
      check("R8 merged input clears", 16'h0);
   endtask

   task automatic t_bounds();
      do_evt({5'd1, 3'd0}, 2'd2, 1'b1);
      do_route(2'd2, 8'd15);
      check("R7 route 15 connects", 16'h8000);
      do_route(2'd2, 8'd16);
      check("R7 route 16 disconnects", 16'h0);
      do_route(2'd2, 8'hFF);
      check("R7 route 255 disconnects", 16'h0);
      do_route(2'd2, 8'd0);
      check("R7 route 0 connects", 16'h0001);
      do_evt({5'd1, 3'd0}, 2'd2, 1'b0);
   endtask

   task automatic t_timing();
      do_route(2'd2, 8'd11);
      @(negedge clk);
      evt_valid = 1'b1; evt_devfn = {5'd12, 3'd0}; evt_pin = 2'd0; evt_level = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      lv[2] = 1'b1;
      check("R9 no change in capture cycle", 16'h0);
      @(negedge clk);
      check("R9 change one cycle later", 16'h0800);
      @(negedge clk);
      rt_wr = 1'b1; rt_sel = 2'd2; rt_data = 8'd12;
      @(negedge clk);
      rt_wr = 1'b0;
      rt[2] = 8'd12;
      check("R9 route write not yet visible", 16'h0800);
      @(negedge clk);
      check("R9 route write visible", 16'h1000);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run hung actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_devfn();
      t_plug();
      t_pass();
      t_merge();
      t_bounds();
      t_timing();
      finish_run();
   end
endmodule